// File: doc/BRIEF.md
# Event-Triggered Serial Timeout Comparator

This block runs a bit-period timer next to a serial transceiver and turns it into timed events for interrupts and inter-frame gaps. A selectable transmit or receive event clears the timer and arms a comparator. While the comparator is armed, the timer advances on each bit-period tick. When the count reaches the programmed compare value, a one-cycle match pulse is produced.

A second selectable event disarms the comparator. That event can be the comparator's own match, the start of a transmission, or an edge on the receive line. An optional restart mode clears the count on every match, which gives a periodic tick train. The receive line is watched directly: it idles high, and the block derives its active and inactive edges from it. The baud generator and the transceiver engines are outside the block. They supply the tick and the single-cycle strobes.

Top module: `serial_tmo_cmp`

## Requirements
- R1: Start code 1 selects tx_eof_i, 2 selects tx_done_i, 3 selects the receive line going active, and 4 selects rx_eof_i. The selected event arms the comparator and clears the count to 0, and armed_o rises one cycle later. After that, the count advances by one on each tick_i cycle while armed.
- R2: Start code 0, and the reserved codes 5 to 7, never arm the comparator, whatever events arrive.
- R3: A start event that arrives while the comparator is already armed clears the count to 0 again.
- R4: match_o is high for exactly the one cycle after a tick moves the count to equal cmp_val_i. A cmp_val_i of 0 never matches.
- R5: Stop code 0 disarms the comparator on its own match, and that match still pulses match_o.
- R6: Stop code 1 disarms on tx_start_i, 2 on the receive line going active, and 3 on it going inactive. Reserved stop codes 4 to 7 never disarm. While disarmed, the count holds its value.
- R7: When restart is enabled, every match clears the count to 0. With a stop code other than 0, the comparator stays armed and keeps timing. When restart is disabled, the count keeps advancing past the match and wraps modulo 256.
- R8: With stop code 0 and restart enabled, a match disarms the comparator and leaves the count at 0, so the timer stays idle until the next start event.
- R9: If a start event and a stop event fall in the same cycle, the comparator ends up disarmed.
- R10: The receive line idles high. Going active is a high-to-low change and going inactive is a low-to-high change, both measured against the line level sampled on the previous cycle. The sampled level resets to high.
- R11: Changing a source selector while armed does not change armed_o by itself. The new code only governs later events.
- R12: Reset clears the count, armed_o and match_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_start_sel_i | input | 3 | Start-source code |
| cfg_stop_sel_i | input | 3 | Stop-source code |
| cfg_restart_en_i | input | 1 | Clear count on every match |
| cmp_val_i | input | 8 | Compare value in bit periods |
| tick_i | input | 1 | Bit-period tick |
| tx_eof_i | input | 1 | Transmit end-of-frame strobe |
| tx_done_i | input | 1 | Transmit complete strobe |
| tx_start_i | input | 1 | Transmission start strobe |
| rx_eof_i | input | 1 | Receive end-of-frame strobe |
| rx_line_i | input | 1 | Receive line level, idle high |
| match_o | output | 1 | One-cycle match pulse |
| armed_o | output | 1 | Comparator armed |

## Verification
The bench sweeps every combination of start code, stop code and restart, reserved codes included, under random strobes, ticks and receive-line toggles. This targets same-cycle start and stop: a design that let the start win would stay armed when it should be idle. It also covers re-starts while running, where a design that failed to clear the count would match early. A compare value of 0 is part of the sweep, and a design that treated it as a match would pulse at once. A long run with no stop and no restart checks the 8-bit wrap: a design that saturated or stopped after the first match would lose the second pulse 256 ticks later. Mid-run selector changes and a reset in the middle of a run cover stale arming and a match pulse that survives reset.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    START_OFF     = 3'd0,
    START_TX_EOF  = 3'd1,
    START_TX_DONE = 3'd2,
    START_RX_ACT  = 3'd3,
    START_RX_EOF  = 3'd4
  } start_sel_e;

  typedef enum logic [SEL_W-1:0] {
    STOP_ON_MATCH = 3'd0,
    STOP_TX_START = 3'd1,
    STOP_RX_ACT   = 3'd2,
    STOP_RX_IDLE  = 3'd3
  } stop_sel_e;
endpackage

// File: rtl/stc_rx_edge.sv
module stc_rx_edge #(
  parameter logic RX_IDLE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_line_i,
  output logic rx_act_o,
  output logic rx_idle_o
);
  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= RX_IDLE;
    else         line_q <= rx_line_i;
  end

  assign rx_act_o  = (line_q == RX_IDLE) && (rx_line_i != RX_IDLE);
  assign rx_idle_o = (line_q != RX_IDLE) && (rx_line_i == RX_IDLE);

  a_r10_act_after_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_act_o |=> !rx_act_o);
  a_r10_edges_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_act_o |=> !$past(rx_idle_o));
endmodule

// File: rtl/stc_evt_sel.sv
module stc_evt_sel
  import stc_pkg::*;
(
  input  logic [SEL_W-1:0] start_sel_i,
  input  logic [SEL_W-1:0] stop_sel_i,
  input  logic             tx_eof_i,
  input  logic             tx_done_i,
  input  logic             tx_start_i,
  input  logic             rx_eof_i,
  input  logic             rx_act_i,
  input  logic             rx_idle_i,
  output logic             start_o,
  output logic             stop_o,
  output logic             stop_on_match_o
);
  always_comb begin
    case (start_sel_i)
      START_TX_EOF:  start_o = tx_eof_i;
      START_TX_DONE: start_o = tx_done_i;
      START_RX_ACT:  start_o = rx_act_i;
      START_RX_EOF:  start_o = rx_eof_i;
      default:       start_o = 1'b0;   // off and reserved codes
    endcase
  end

  always_comb begin
    case (stop_sel_i)
      STOP_TX_START: stop_o = tx_start_i;
      STOP_RX_ACT:   stop_o = rx_act_i;
      STOP_RX_IDLE:  stop_o = rx_idle_i;
      default:       stop_o = 1'b0;
    endcase
  end

  assign stop_on_match_o = (stop_sel_i == STOP_ON_MATCH);
endmodule

// File: rtl/stc_timer_core.sv
module stc_timer_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             stop_on_match_i,
  input  logic             restart_en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             match_o,
  output logic             armed_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             armed_q, armed_d, match_q, hit, kill;

  assign cnt_inc = cnt_q + 1'b1;
  assign hit     = armed_q && tick_i && (cmp_i != '0) && (cnt_inc == cmp_i);
  assign kill    = stop_i || (hit && stop_on_match_i);

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (armed_q && tick_i) cnt_d = cnt_inc;
    if (hit && restart_en_i) cnt_d = '0;
    if (kill) begin
      armed_d = 1'b0;           // stop beats a same-cycle start
    end else if (start_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      match_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      match_q <= hit;
    end
  end

  assign match_o = match_q;
  assign armed_o = armed_q;

  a_r4_match_from_armed_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q |-> $past(armed_q && tick_i));
  a_r4_no_zero_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q |-> ($past(cmp_i) != '0));
  a_r9_stop_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !armed_q);
  a_r3_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && !stop_on_match_i) |=> (armed_q && cnt_q == '0));
  a_r7_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_q && $past(restart_en_i)) |-> (cnt_q == '0));
  a_r1_arm_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(start_i));
  a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/serial_tmo_cmp.sv
module serial_tmo_cmp
  import stc_pkg::*;
#(
  parameter int unsigned CMP_W   = 8,
  parameter logic        RX_IDLE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] cfg_start_sel_i,
  input  logic [SEL_W-1:0] cfg_stop_sel_i,
  input  logic             cfg_restart_en_i,
  input  logic [CMP_W-1:0] cmp_val_i,
  input  logic             tick_i,
  input  logic             tx_eof_i,
  input  logic             tx_done_i,
  input  logic             tx_start_i,
  input  logic             rx_eof_i,
  input  logic             rx_line_i,
  output logic             match_o,
  output logic             armed_o
);
  logic rx_act, rx_idle, start_ev, stop_ev, stop_on_match;

  stc_rx_edge #(.RX_IDLE(RX_IDLE)) u_rx_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_line_i (rx_line_i),
    .rx_act_o  (rx_act),
    .rx_idle_o (rx_idle)
  );

  stc_evt_sel u_evt_sel (
    .start_sel_i     (cfg_start_sel_i),
    .stop_sel_i      (cfg_stop_sel_i),
    .tx_eof_i        (tx_eof_i),
    .tx_done_i       (tx_done_i),
    .tx_start_i      (tx_start_i),
    .rx_eof_i        (rx_eof_i),
    .rx_act_i        (rx_act),
    .rx_idle_i       (rx_idle),
    .start_o         (start_ev),
    .stop_o          (stop_ev),
    .stop_on_match_o (stop_on_match)
  );

  stc_timer_core #(.CNT_W(CMP_W)) u_core (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (start_ev),
    .stop_i          (stop_ev),
    .stop_on_match_i (stop_on_match),
    .restart_en_i    (cfg_restart_en_i),
    .tick_i          (tick_i),
    .cmp_i           (cmp_val_i),
    .match_o         (match_o),
    .armed_o         (armed_o)
  );

  a_r2_arm_needs_valid_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> ($past(cfg_start_sel_i) != 3'd0 && $past(cfg_start_sel_i) <= 3'd4));
  a_r12_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!armed_o && !match_o));
endmodule

// File: tb/serial_tmo_cmp_tb_top.sv
module serial_tmo_cmp_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] start_sel = 3'd0, stop_sel = 3'd0;
  logic       restart_en = 1'b0;
  logic [7:0] cmp_val = 8'd0;
  logic       tick = 1'b0, tx_eof = 1'b0, tx_done = 1'b0, tx_start = 1'b0, rx_eof = 1'b0;
  logic       rx_line = 1'b1;
  logic       match_o, armed_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string tag = "R12";

  // reference state
  int m_cnt = 0;
  bit m_armed = 0, m_match = 0, m_rx = 1;

  always #4 clk_i = ~clk_i;

  serial_tmo_cmp dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_start_sel_i(start_sel), .cfg_stop_sel_i(stop_sel),
    .cfg_restart_en_i(restart_en), .cmp_val_i(cmp_val),
    .tick_i(tick), .tx_eof_i(tx_eof), .tx_done_i(tx_done),
    .tx_start_i(tx_start), .rx_eof_i(rx_eof), .rx_line_i(rx_line),
    .match_o(match_o), .armed_o(armed_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    bit act, inact, st, sp, hit, kill;
    int nc;
    if (!rst_ni) begin
      m_cnt = 0; m_armed = 0; m_match = 0; m_rx = 1;
    end else begin
      act   = m_rx && !rx_line;
      inact = !m_rx && rx_line;
      case (start_sel)
        3'd1: st = tx_eof;  3'd2: st = tx_done;
        3'd3: st = act;     3'd4: st = rx_eof;
        default: st = 0;
      endcase
      case (stop_sel)
        3'd1: sp = tx_start; 3'd2: sp = act; 3'd3: sp = inact;
        default: sp = 0;
      endcase
      nc = m_cnt; hit = 0;
      if (m_armed && tick) begin
        nc = (m_cnt + 1) % 256;
        hit = (cmp_val != 0) && (nc == cmp_val);
      end
      if (hit && restart_en) nc = 0;
      kill = sp || (hit && stop_sel == 3'd0);
      if (kill) m_armed = 0;
      else if (st) begin m_armed = 1; nc = 0; end
      m_cnt = nc; m_match = hit; m_rx = rx_line;
    end
  end

  task automatic check();
    n_cmp++;
    if (match_o !== m_match || armed_o !== m_armed) begin
      n_bad++;
      $display("FAIL %s t=%0t match=%b armed=%b expected match=%b armed=%b (start=%0d stop=%0d rst=%b cmp=%0d)",
               tag, $time, match_o, armed_o, m_match, m_armed, start_sel, stop_sel, restart_en, cmp_val);
    end
  endtask

  // one cycle: compare at negedge, then drive random stimulus with given rates
  task automatic step(int p_tick, int p_ev, int p_rx);
    @(negedge clk_i);
    check();
    tick     = ($urandom % 100) < p_tick;
    tx_eof   = ($urandom % 1000) < p_ev;
    tx_done  = ($urandom % 1000) < p_ev;
    tx_start = ($urandom % 1000) < p_ev;
    rx_eof   = ($urandom % 1000) < p_ev;
    if (($urandom % 100) < p_rx) rx_line = ~rx_line;
  endtask

  task automatic quiet();
    tick = 0; tx_eof = 0; tx_done = 0; tx_start = 0; rx_eof = 0;
  endtask

  function automatic string tag_for(int s, int p, bit r);
    string t;
    t = (s == 0 || s > 4) ? "R2" : "R1 R3 R4";
    t = {t, (p == 0) ? " R5" : " R6 R10", r ? " R7 R8" : " R7", " R9"};
    return t;
  endfunction

  initial begin
    #1_200_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    tag = "R12";
    repeat (3) @(negedge clk_i);
    check();
    rst_ni = 1'b1;

    // R1..R10 sweep over every selector combination, reserved codes included
    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 8; p++)
        for (int r = 0; r < 2; r++) begin
          @(negedge clk_i);
          start_sel = 3'(s); stop_sel = 3'(p); restart_en = r[0];
          cmp_val = ($urandom % 8 == 0) ? 8'd0 : 8'(1 + $urandom % 6);
          tag = tag_for(s, p, r[0]);
          for (int k = 0; k < 300; k++) step(60, 40, 8);
        end
    quiet();

    // R7: wrap past 255 with no restart and no stop
    tag = "R7";
    @(negedge clk_i);
    start_sel = 3'd1; stop_sel = 3'd5; restart_en = 0; cmp_val = 8'd10;
    tx_eof = 1;
    @(negedge clk_i); check(); tx_eof = 0; tick = 1;
    for (int k = 0; k < 600; k++) begin @(negedge clk_i); check(); end
    quiet();

    // R9: start and stop in the same cycle
    tag = "R9";
    start_sel = 3'd2; stop_sel = 3'd1;
    tx_done = 1; tx_start = 1;
    @(negedge clk_i); check(); quiet();
    @(negedge clk_i); check();

    // R11: selectors change while armed
    tag = "R11";
    for (int k = 0; k < 4000; k++) begin
      if (k % 50 == 25) begin
        start_sel = 3'($urandom % 8); stop_sel = 3'($urandom % 8);
      end
      step(50, 30, 6);
    end

    // R12: reset in the middle of a restart run suppresses the pending pulse
    tag = "R12";
    start_sel = 3'd1; stop_sel = 3'd4; restart_en = 1; cmp_val = 8'd1;
    tx_eof = 1;
    @(negedge clk_i); check(); tx_eof = 0; tick = 1;
    for (int k = 0; k < 5; k++) begin @(negedge clk_i); check(); end
    rst_ni = 0;
    #1; check();
    @(negedge clk_i); check();
    rst_ni = 1;
    for (int k = 0; k < 5; k++) begin @(negedge clk_i); check(); end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule